// File: doc/BRIEF.md
# A/D Conversion Timing Sequencer

This block times a successive-approximation A/D converter from a fast reference clock. It holds the converter's enable bit and a 3-bit timing mode. When the enable bit is set, or when the channel selection is written while the converter is on, it runs a sequence with three phases. The first is a start delay, the second a sampling window with a strobe for the track-and-hold, and the third the rest of the conversion. An end-of-conversion interrupt pulse closes the sequence. While the enable bit stays set, conversions repeat back to back. The comparator, the bit-decision logic and the bus side are outside this block.

Six mode codes are legal, and each fixes a total conversion time, a sampling length and a start-delay range. The delay used is the range minimum plus an alignment of up to three cycles to a free-running 4-cycle phase counter, clamped to the range maximum. A start with an unlisted code is refused and raises an error flag. A lock input marks the state in which the system runs from its slow clock with the main oscillator stopped. While the lock is high, every control write is discarded.

Top module: `adc_seq_timer`

## Requirements
- R1: While and after reset, `sample_en`, `busy`, `eoc_irq` and `mode_err` are 0, and the internal phase counter is 0.
- R2: A start happens when `cfg_wr` sets `cfg_en`=1 while the enable bit is 0. Rewriting 1 over 1 does not start. The start delay is D = min(dmin + ((4 - p) mod 4), dmax), where p is the phase counter value at the capturing edge. The counter resets to 0 and increments on every clock edge after reset is released. `sample_en` first rises D cycles after the capturing edge.
- R3: The mode codes map to (total, sampling, dmin, dmax) in reference-clock cycles as follows: 3'b000 = (288, 40, 32, 36); 3'b001 = (240, 32, 28, 32); 3'b010 = (192, 24, 24, 28); 3'b100 = (144, 20, 16, 18); 3'b101 = (120, 16, 14, 16); 3'b110 = (96, 12, 12, 14).
- R4: `sample_en` stays high for exactly the sampling length of the mode, and it is only ever high while `busy` is high.
- R5: `eoc_irq` is a one-cycle pulse that appears D + total cycles after the capturing edge of a start.
- R6: While enabled, the next conversion follows without a start delay. `sample_en` is high in the same cycle as `eoc_irq`, and successive interrupts are the mode's total time apart.
- R7: Writing the enable bit to 0 drops `busy` and `sample_en` in the next cycle, and no interrupt follows.
- R8: An accepted `chan_wr` while enabled restarts the sequence from the start delay and discards the running conversion. A `chan_wr` while disabled has no effect.
- R9: A start or repeat with code 3'b011 or 3'b111 begins no conversion. It sets `mode_err` and leaves `busy` low. `mode_err` clears on the next legal start or when the enable bit is written to 0.
- R10: While `wr_lock` is high, `cfg_wr` and `chan_wr` are ignored. A running sequence continues and a stopped one stays stopped.
- R11: The mode code is taken at each start and at each repeat. A mode write during a conversion changes only the conversions that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| wr_lock | input | 1 | High while control writes must be discarded |
| cfg_wr | input | 1 | Strobe that writes enable bit and mode code |
| cfg_en | input | 1 | Enable bit value carried by cfg_wr |
| cfg_mode | input | 3 | Timing mode code carried by cfg_wr |
| chan_wr | input | 1 | Strobe marking a channel-select write |
| sample_en | output | 1 | Sampling window strobe |
| busy | output | 1 | A sequence is in progress |
| eoc_irq | output | 1 | End-of-conversion pulse |
| mode_err | output | 1 | A start was refused for a prohibited mode code |

## Verification
The assertions assume that the write strobes are synchronous single-cycle pulses. They also assume that reset is released away from a clock edge, so that the phase counter and the first sequence share a known origin. The bench drives every strobe on the falling edge and holds it for one cycle only. It raises `wr_lock` only between edges, so the lock assertions see a clean relation between the lock and the held register values. Each test begins from a known disabled state, written through the normal enable bit, so that no sequence is already running when a new start is stimulated.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int MODE_W = 3;
  localparam int CNT_W  = 9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DLY  = 2'd1,
    ST_SMP  = 2'd2,
    ST_CNV  = 2'd3
  } seq_st_t;

  typedef struct packed {
    logic             legal;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] samp;
    logic [CNT_W-1:0] dmin;
    logic [CNT_W-1:0] dmax;
  } prof_t;

  function automatic prof_t prof_lookup(input logic [MODE_W-1:0] code);
    prof_t p;
    p = '0;
    unique case (code)
      3'b000:  p = '{1'b1, 9'd288, 9'd40, 9'd32, 9'd36};
      3'b001:  p = '{1'b1, 9'd240, 9'd32, 9'd28, 9'd32};
      3'b010:  p = '{1'b1, 9'd192, 9'd24, 9'd24, 9'd28};
      3'b100:  p = '{1'b1, 9'd144, 9'd20, 9'd16, 9'd18};
      3'b101:  p = '{1'b1, 9'd120, 9'd16, 9'd14, 9'd16};
      3'b110:  p = '{1'b1, 9'd96,  9'd12, 9'd12, 9'd14};
      default: p = '{1'b0, 9'd0,   9'd0,  9'd0,  9'd0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              chan_wr,
  output logic              en_q,
  output logic              en_nxt,
  output logic [MODE_W-1:0] mode_nxt,
  output logic              start,
  output logic [PH_W-1:0]   phase
);

  logic [MODE_W-1:0] mode_q;
  logic              cfg_ok;
  logic              chan_ok;

  // writes are dropped entirely while the lock is up
  assign cfg_ok   = cfg_wr  & ~wr_lock;
  assign chan_ok  = chan_wr & ~wr_lock;
  assign en_nxt   = cfg_ok ? cfg_en   : en_q;
  assign mode_nxt = cfg_ok ? cfg_mode : mode_q;
  assign start    = (cfg_ok & cfg_en & ~en_q) | (chan_ok & en_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= '0;
    end else if (cfg_ok) begin
      en_q   <= cfg_en;
      mode_q <= cfg_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock |=> ($stable(en_q) && $stable(mode_q)));

  p_chan_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_wr && !en_q && !cfg_wr) |-> !start);

endmodule

// File: rtl/adc_seq_prof.sv
module adc_seq_prof
  import adc_seq_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic [MODE_W-1:0] code,
  input  logic [PH_W-1:0]   phase,
  output logic              legal,
  output logic [CNT_W-1:0]  samp,
  output logic [CNT_W-1:0]  total,
  output logic [CNT_W-1:0]  delay
);

  prof_t            prof;
  logic [PH_W-1:0]  to_wrap;
  logic [CNT_W-1:0] raw_dly;

  assign prof    = prof_lookup(code);
  // cycles left until the phase counter wraps to zero
  assign to_wrap = {PH_W{1'b0}} - phase;
  assign raw_dly = prof.dmin + CNT_W'(to_wrap);

  assign legal = prof.legal;
  assign samp  = prof.samp;
  assign total = prof.total;
  assign delay = (raw_dly > prof.dmax) ? prof.dmax : raw_dly;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              en_nxt,
  input  logic [MODE_W-1:0] mode_nxt,
  input  logic              legal,
  input  logic [CNT_W-1:0]  samp,
  input  logic [CNT_W-1:0]  total,
  input  logic [CNT_W-1:0]  delay,
  output logic [MODE_W-1:0] sel_mode,
  output logic              busy,
  output logic              sample_en,
  output logic              eoc,
  output logic              err
);

  seq_st_t           st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [MODE_W-1:0] lat_q, lat_n;
  logic              eoc_n, err_n;
  logic              reload;

  // profile is read from the new code on a load, else from the latched one
  assign reload   = start | ((st_q == ST_CNV) && (cnt_q == '0));
  assign sel_mode = reload ? mode_nxt : lat_q;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    lat_n = lat_q;
    eoc_n = 1'b0;
    err_n = err;
    if (!en_nxt) begin
      st_n  = ST_IDLE;
      err_n = 1'b0;
    end else if (start) begin
      if (legal) begin
        st_n  = ST_DLY;
        cnt_n = delay - 1'b1;
        lat_n = mode_nxt;
        err_n = 1'b0;
      end else begin
        st_n  = ST_IDLE;
        err_n = 1'b1;
      end
    end else begin
      unique case (st_q)
        ST_DLY: begin
          if (cnt_q == '0) begin
            st_n  = ST_SMP;
            cnt_n = samp - 1'b1;
          end else cnt_n = cnt_q - 1'b1;
        end
        ST_SMP: begin
          if (cnt_q == '0) begin
            st_n  = ST_CNV;
            cnt_n = total - samp - 1'b1;
          end else cnt_n = cnt_q - 1'b1;
        end
        ST_CNV: begin
          if (cnt_q == '0) begin
            eoc_n = 1'b1;
            if (legal) begin
              st_n  = ST_SMP;
              cnt_n = samp - 1'b1;
              lat_n = mode_nxt;
            end else begin
              st_n  = ST_IDLE;
              err_n = 1'b1;
            end
          end else cnt_n = cnt_q - 1'b1;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      lat_q <= '0;
      eoc   <= 1'b0;
      err   <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      lat_q <= lat_n;
      eoc   <= eoc_n;
      err   <= err_n;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign sample_en = (st_q == ST_SMP);

  p_start_dly_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && legal) |=> (st_q == ST_DLY));

  p_dly_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DLY) |-> (cnt_q < 9'd36));

  p_samp_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy);

  p_eoc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_nxt |=> (!busy && !eoc));

  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              chan_wr,
  output logic              sample_en,
  output logic              busy,
  output logic              eoc_irq,
  output logic              mode_err
);

  logic              en_q, en_nxt, start, legal;
  logic [MODE_W-1:0] mode_nxt, sel_mode;
  logic [PH_W-1:0]   phase;
  logic [CNT_W-1:0]  samp, total, delay;

  adc_seq_ctl #(.PH_W(PH_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_lock(wr_lock), .cfg_wr(cfg_wr),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode), .chan_wr(chan_wr),
    .en_q(en_q), .en_nxt(en_nxt), .mode_nxt(mode_nxt),
    .start(start), .phase(phase)
  );

  adc_seq_prof #(.PH_W(PH_W)) u_prof (
    .code(sel_mode), .phase(phase), .legal(legal),
    .samp(samp), .total(total), .delay(delay)
  );

  adc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .en_nxt(en_nxt),
    .mode_nxt(mode_nxt), .legal(legal), .samp(samp), .total(total),
    .delay(delay), .sel_mode(sel_mode), .busy(busy),
    .sample_en(sample_en), .eoc(eoc_irq), .err(mode_err)
  );

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!busy && !sample_en));

endmodule

// File: tb/sim_adc_seq_timer.sv
module sim_adc_seq_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [2:0] VMODE [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam int         VWAIT [NV] = '{0, 1, 2, 3, 5, 6, 7, 2};

  logic clk = 1'b0;
  logic rst_n, wr_lock, cfg_wr, cfg_en, chan_wr;
  logic [2:0] cfg_mode;
  logic sample_en, busy, eoc_irq, mode_err;
  int n_chk = 0;
  int n_bad = 0;
  int ec;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_lock(wr_lock), .cfg_wr(cfg_wr),
    .cfg_en(cfg_en), .cfg_mode(cfg_mode), .chan_wr(chan_wr),
    .sample_en(sample_en), .busy(busy), .eoc_irq(eoc_irq), .mode_err(mode_err)
  );

  // edges since reset release, tracked by the bench (R2 phase origin)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ec <= 0;
    else        ec <= ec + 1;
  end

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R3 profile table as stated in the requirements
  task automatic prof(input logic [2:0] m, output int tot, output int smp,
                      output int dmn, output int dmx);
    case (m)
      3'd0: begin tot = 288; smp = 40; dmn = 32; dmx = 36; end
      3'd1: begin tot = 240; smp = 32; dmn = 28; dmx = 32; end
      3'd2: begin tot = 192; smp = 24; dmn = 24; dmx = 28; end
      3'd4: begin tot = 144; smp = 20; dmn = 16; dmx = 18; end
      3'd5: begin tot = 120; smp = 16; dmn = 14; dmx = 16; end
      3'd6: begin tot = 96;  smp = 12; dmn = 12; dmx = 14; end
      default: begin tot = 0; smp = 0; dmn = 0; dmx = 0; end
    endcase
  endtask

  function automatic int exp_dly(input int dmn, input int dmx, input int p);
    int d;
    d = dmn + ((4 - p) % 4);
    return (d > dmx) ? dmx : d;
  endfunction

  task automatic wr_cfg(input logic en, input logic [2:0] m);
    cfg_wr = 1'b1; cfg_en = en; cfg_mode = m;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  // strobes already driven at this negedge; j counts negedges after the capturing edge
  task automatic meas(input logic [2:0] m, input string rq, output int eoc_j);
    int tot, smp, dmn, dmx, d, first, scnt, p;
    p = ec % 4;
    prof(m, tot, smp, dmn, dmx);
    d = exp_dly(dmn, dmx, p);
    first = -1; scnt = 0; eoc_j = -1;
    for (int j = 0; j < 1000 && eoc_j < 0; j++) begin
      @(negedge clk);
      if (j == 0) begin cfg_wr = 1'b0; chan_wr = 1'b0; end
      if (eoc_irq) eoc_j = j;
      else begin
        if (sample_en && first < 0) first = j;
        if (sample_en) scnt++;
      end
    end
    chk({rq, " R2 R3 delay"}, first, d);
    chk({rq, " R4 sample width"}, scnt, smp);
    chk({rq, " R5 eoc time"}, eoc_j, d + tot);
  endtask

  task automatic to_next_eoc(output int n);
    n = -1;
    for (int j = 1; j <= 1000 && n < 0; j++) begin
      @(negedge clk);
      if (j == 1) cfg_wr = 1'b0;
      if (eoc_irq) n = j;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ej, n1, n2, tot, smp, dmn, dmx, d, hits;
    rst_n = 1'b0; wr_lock = 1'b0; cfg_wr = 1'b0; cfg_en = 1'b0;
    cfg_mode = 3'd0; chan_wr = 1'b0;
    tick(3);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 sample_en", sample_en, 0);
    chk("R1 eoc_irq", eoc_irq, 0);
    chk("R1 mode_err", mode_err, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 busy after release", busy, 0);

    // vector walk over every mode code with varied phase
    for (int v = 0; v < NV; v++) begin
      wr_cfg(1'b0, 3'd0);
      tick(VWAIT[v]);
      cfg_wr = 1'b1; cfg_en = 1'b1; cfg_mode = VMODE[v];
      prof(VMODE[v], tot, smp, dmn, dmx);
      if (tot > 0) meas(VMODE[v], "vec", ej);
      else begin
        tick(1); cfg_wr = 1'b0;
        chk("R9 err on refused start", mode_err, 1);
        hits = 0;
        for (int j = 0; j < 20; j++) begin tick(1); if (busy) hits++; end
        chk("R9 no conversion", hits, 0);
      end
    end

    // R6 and R11: back-to-back, mode change mid-conversion
    wr_cfg(1'b0, 3'd0);
    cfg_wr = 1'b1; cfg_en = 1'b1; cfg_mode = 3'd6;
    meas(3'd6, "b2b", ej);
    chk("R6 sample_en with eoc", sample_en, 1);
    cfg_wr = 1'b1; cfg_en = 1'b1; cfg_mode = 3'd5;
    to_next_eoc(n1);
    chk("R11 current keeps old total", n1, 96);
    to_next_eoc(n2);
    chk("R6 R11 next uses new total", n2, 120);

    // R7: abort by clearing the enable bit
    wr_cfg(1'b0, 3'd5);
    chk("R7 busy drops", busy, 0);
    chk("R7 sample_en drops", sample_en, 0);
    hits = 0;
    for (int j = 0; j < 400; j++) begin tick(1); if (eoc_irq) hits++; end
    chk("R7 no eoc after abort", hits, 0);

    // R8: channel write while disabled is ignored
    chan_wr = 1'b1; tick(1); chan_wr = 1'b0;
    hits = 0;
    for (int j = 0; j < 50; j++) begin tick(1); if (busy) hits++; end
    chk("R8 chan write while off", hits, 0);

    // R8: channel write mid-conversion restarts from the delay
    wr_cfg(1'b1, 3'd0);
    tick(100);
    chk("R8 running before restart", busy, 1);
    chan_wr = 1'b1;
    meas(3'd0, "R8 restart", ej);

    // R10: writes ignored while locked
    wr_cfg(1'b0, 3'd0);
    wr_lock = 1'b1;
    wr_cfg(1'b1, 3'd0);
    chan_wr = 1'b1; tick(1); chan_wr = 1'b0;
    hits = 0;
    for (int j = 0; j < 50; j++) begin tick(1); if (busy) hits++; end
    chk("R10 locked enable ignored", hits, 0);
    wr_lock = 1'b0;
    prof(3'd6, tot, smp, dmn, dmx);
    cfg_wr = 1'b1; cfg_en = 1'b1; cfg_mode = 3'd6;
    d = exp_dly(dmn, dmx, ec % 4);
    tick(1); cfg_wr = 1'b0;
    tick(19);
    wr_lock = 1'b1; cfg_wr = 1'b1; cfg_en = 1'b0; chan_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0; chan_wr = 1'b0;
    ej = -1;
    for (int j = 20; j < 1000 && ej < 0; j++) begin
      if (eoc_irq) ej = j;
      else tick(1);
    end
    chk("R10 locked abort ignored", ej, d + tot);
    wr_lock = 1'b0;

    // R9: error persists until a legal start, cleared by disable
    wr_cfg(1'b0, 3'd0);
    wr_cfg(1'b1, 3'd7);
    chk("R9 err set", mode_err, 1);
    wr_cfg(1'b1, 3'd5);
    chk("R2 R9 rewrite of 1 does not start", busy, 0);
    chk("R9 err held", mode_err, 1);
    chan_wr = 1'b1;
    meas(3'd5, "R9 legal restart", ej);
    chk("R9 err cleared by legal start", mode_err, 0);
    wr_cfg(1'b0, 3'd0);
    wr_cfg(1'b1, 3'd3);
    chk("R9 err set again", mode_err, 1);
    wr_cfg(1'b0, 3'd0);
    chk("R9 err cleared by disable", mode_err, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule